// File: doc/BRIEF.md
# Per-Core Interrupt Countdown Timer

This block is the countdown timer of a per-core interrupt controller. Software programs three things through a small strobe-based register port: the timer entry (vector, mask, mode), a prescale selector and an initial count. Writing the initial count takes the current cycle as the new load time and starts a fresh schedule. Elapsed timer ticks are the clock cycles since that load, divided by a power of two.

The timer runs in one of two modes. In one-shot mode it expires once, when the elapsed tick count reaches the initial count plus one. In periodic mode it expires on every whole multiple of that period, counted from the load time. Each expiry produces a one-cycle interrupt request that carries the programmed vector. A masked entry, or a zero count, disarms the timer. A fourth register returns the live countdown value.

Top module: `core_irq_timer`

## Requirements
- R1: While entry bit 16 (mask) is set, no interrupt request is produced. Setting the mask on a running periodic timer stops any further requests.
- R2: Divide register bits 2:0 hold a shift s from 0 to 7, and one timer tick elapses every 2^s clock cycles counted from the load. Upper write bits are dropped, so reading the register back gives only bits 2:0.
- R3: In one-shot mode (entry bit 17 clear) with initial count N > 0, exactly one request appears, in the cycle after clock edge (N+1)·2^s counted from the load edge.
- R4: In one-shot mode no request is scheduled when the elapsed ticks already equal or exceed the initial count at evaluation time. An initial count of zero therefore never fires, and neither does a late unmask.
- R5: In periodic mode (entry bit 17 set) with N > 0, requests appear after edges k·(N+1)·2^s for k = 1, 2, ….
- R6: In periodic mode an initial count of zero never fires.
- R7: After synchronous reset the entry reads 0x0001_0000 (masked, vector 0), the divide and count registers read 0, and no request is pending.
- R8: Writing the initial count (register 2) restarts the schedule from that write edge and discards the previous one.
- R9: A request is a single-cycle pulse on irq_valid, and irq_vector carries entry bits 7:0.
- R10: Register 3 reads initial count minus (elapsed ticks mod period) in periodic mode. In one-shot mode it reads initial count minus elapsed ticks, and 0 once the timer has expired.
- R11: A write to the entry (register 0) re-evaluates the schedule at once with the rules of a fresh load, keeping the existing load time. Switching a finished one-shot timer to periodic re-arms it at the next period boundary.
- R12: Register reads return data one cycle after rd_en, and registers 0, 1 and 2 read back the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register select: 0 entry, 1 divide, 2 initial count, 3 current count |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |

## Verification
The bench goes after off-by-one expiry. A design that counts the load edge as a tick, or compares against N instead of N+1, fires one tick early, and the first-expiry cycle of each table row shows it. Periodic re-arm errors show up either as a late second pulse or as a train of back-to-back pulses. Zero-count handling is probed in both modes: a one-shot timer at zero must stay silent, where a naive design would fire at tick one. Entry rewrites are probed at three points: unmask before the count is reached (must fire), unmask after it is passed (must not), and a switch to periodic after a finished one-shot (must re-arm on the boundary measured from the original load). A design that reset the load time on entry writes would miss that boundary.

// File: rtl/cit_pkg.sv
package cit_pkg;
  localparam int DATA_W = 32;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_INIT  = 2'd2,
    SEL_CUR   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cit_regs.sv
module cit_regs
  import cit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8,
  parameter int DIV_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [VEC_W-1:0]  vec,
  output logic              masked,
  output logic              periodic,
  output logic [DIV_W-1:0]  shift,
  output logic [CNT_W-1:0]  init_count,
  output logic              load,
  output logic [CNT_W-1:0]  load_value,
  output logic              entry_wr,
  output logic              entry_wr_masked,
  output logic              entry_wr_periodic
);
  logic [VEC_W-1:0] vec_q;
  logic             mask_q, per_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] init_q;

  always_comb begin
    entry_wr          = wr_en && (reg_sel_e'(addr) == SEL_ENTRY);
    load              = wr_en && (reg_sel_e'(addr) == SEL_INIT);
    load_value        = wdata[CNT_W-1:0];
    entry_wr_masked   = wdata[MASK_BIT];
    entry_wr_periodic = wdata[MODE_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
      div_q  <= '0;
      init_q <= '0;
    end else if (wr_en) begin
      unique case (reg_sel_e'(addr))
        SEL_ENTRY: begin
          vec_q  <= wdata[VEC_W-1:0];
          mask_q <= wdata[MASK_BIT];
          per_q  <= wdata[MODE_BIT];
        end
        SEL_DIV:  div_q  <= wdata[DIV_W-1:0];
        SEL_INIT: init_q <= wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  assign vec        = vec_q;
  assign masked     = mask_q;
  assign periodic   = per_q;
  assign shift      = div_q;
  assign init_count = init_q;
endmodule

// File: rtl/cit_prescale.sv
module cit_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] shift,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  generate
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign low_mask[i] = (i < int'(shift));
    end
  endgenerate

  assign tick = &(pre_q | ~low_mask);

  always_ff @(posedge clk) begin
    if (rst || load) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cit_count.sv
module cit_count #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_value,
  input  logic             entry_wr,
  input  logic             entry_wr_masked,
  input  logic             entry_wr_periodic,
  input  logic             tick,
  input  logic             masked,
  input  logic             periodic,
  input  logic [VEC_W-1:0] vec,
  input  logic [CNT_W-1:0] init_count,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int EL_W = CNT_W + 1;

  logic [EL_W-1:0]  elapsed_q;
  logic [CNT_W-1:0] phase_q;
  logic             armed_q, irq_q;
  logic [VEC_W-1:0] irq_vec_q;
  logic             at_end, reached, expired, fire;

  always_comb begin
    at_end    = (phase_q == init_count);
    reached   = elapsed_q >= {1'b0, init_count};
    expired   = elapsed_q >  {1'b0, init_count};
    fire      = armed_q && !masked && tick && at_end;
    cur_count = (!periodic && expired) ? '0 : (init_count - phase_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
      phase_q   <= '0;
      armed_q   <= 1'b0;
      irq_q     <= 1'b0;
      irq_vec_q <= '0;
    end else begin
      irq_q <= 1'b0;
      if (load) begin
        elapsed_q <= '0;
        phase_q   <= '0;
        armed_q   <= !masked && (load_value != '0);
      end else begin
        if (tick) begin
          if (!(&elapsed_q)) elapsed_q <= elapsed_q + 1'b1;
          phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
        if (entry_wr)
          armed_q <= !entry_wr_masked &&
                     (entry_wr_periodic ? (init_count != '0) : !reached);
        else if (fire && !periodic)
          armed_q <= 1'b0;
        if (fire) begin
          irq_q     <= 1'b1;
          irq_vec_q <= vec;
        end
      end
    end
  end

  assign irq_valid  = irq_q;
  assign irq_vector = irq_vec_q;
endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
  import cit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8,
  parameter int DIV_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [VEC_W-1:0]  vec_w;
  logic              mask_w, per_w, load_w, ewr_w, ewr_mask_w, ewr_per_w, tick_w;
  logic [DIV_W-1:0]  shift_w;
  logic [CNT_W-1:0]  init_w, load_val_w, cur_w;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  cit_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .vec(vec_w), .masked(mask_w), .periodic(per_w), .shift(shift_w),
    .init_count(init_w), .load(load_w), .load_value(load_val_w),
    .entry_wr(ewr_w), .entry_wr_masked(ewr_mask_w),
    .entry_wr_periodic(ewr_per_w)
  );

  cit_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .load(load_w), .shift(shift_w), .tick(tick_w)
  );

  cit_count #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_w), .load_value(load_val_w),
    .entry_wr(ewr_w), .entry_wr_masked(ewr_mask_w),
    .entry_wr_periodic(ewr_per_w), .tick(tick_w), .masked(mask_w),
    .periodic(per_w), .vec(vec_w), .init_count(init_w),
    .cur_count(cur_w), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel_e'(addr))
      SEL_ENTRY: begin
        rd_mux[VEC_W-1:0] = vec_w;
        rd_mux[MASK_BIT]  = mask_w;
        rd_mux[MODE_BIT]  = per_w;
      end
      SEL_DIV:  rd_mux[DIV_W-1:0] = shift_w;
      SEL_INIT: rd_mux[CNT_W-1:0] = init_w;
      SEL_CUR:  rd_mux[CNT_W-1:0] = cur_w;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector,
  input logic             entry_masked,
  input logic [VEC_W-1:0] entry_vec,
  input logic [CNT_W-1:0] init_count,
  input logic             load
);
  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |=> !irq_valid);

  assert_vector_R9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector == $past(entry_vec)));

  assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(entry_masked));

  assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ($past(init_count) != '0));

  assert_load_restart_R8: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(load));
endmodule

bind core_irq_timer cit_checker #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_vector(irq_vector),
  .entry_masked(mask_w), .entry_vec(vec_w), .init_count(init_w),
  .load(load_w)
);

// File: tb/core_irq_timer_tb.sv
module core_irq_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  core_irq_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );

  typedef struct packed {
    logic        per;
    logic [31:0] ic;
    logic [2:0]  sh;
    logic [7:0]  vec;
    logic [31:0] first;
  } row_t;

  localparam row_t TBL [5] = '{
    '{per: 1'b0, ic: 32'd3, sh: 3'd0, vec: 8'h21, first: 32'd4},
    '{per: 1'b0, ic: 32'd5, sh: 3'd2, vec: 8'h22, first: 32'd24},
    '{per: 1'b1, ic: 32'd2, sh: 3'd0, vec: 8'h23, first: 32'd3},
    '{per: 1'b1, ic: 32'd4, sh: 3'd1, vec: 8'h24, first: 32'd10},
    '{per: 1'b1, ic: 32'd1, sh: 3'd7, vec: 8'h25, first: 32'd256}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_irq(input int limit, input bit stop,
                          output int first, output int second, output logic [7:0] v);
    first = 0; second = 0; v = '0;
    for (int j = 1; j <= limit; j++) begin
      @(negedge clk);
      if (irq_valid) begin
        if (first == 0) begin first = j; v = irq_vector; end
        else if (second == 0) second = j;
      end
      if (stop && first != 0) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  v;
    int f, s;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: reset state
    check(irq_valid == 1'b0, "R7 irq idle", irq_valid, 0);
    rd(2'd0, d); check(d == 32'h0001_0000, "R7 entry", d, 32'h0001_0000);
    rd(2'd1, d); check(d == 0, "R7 divide", d, 0);
    rd(2'd3, d); check(d == 0, "R7 current", d, 0);

    // R3 R5 R2 R9: vector table
    for (int i = 0; i < 5; i++) begin
      int lim;
      wr(2'd0, {14'd0, TBL[i].per, 1'b0, 8'd0, TBL[i].vec});
      wr(2'd1, {29'd0, TBL[i].sh});
      wr(2'd2, TBL[i].ic);
      lim = 2 * int'(TBL[i].first) + int'(TBL[i].first) / 2 + 2;
      wait_irq(lim, 1'b0, f, s, v);
      check(f == int'(TBL[i].first), "R3/R5/R2 first expiry", f, TBL[i].first);
      check(v == TBL[i].vec, "R9 vector", v, TBL[i].vec);
      if (TBL[i].per)
        check(s == 2 * int'(TBL[i].first), "R5 second expiry", s, 2 * TBL[i].first);
      else
        check(s == 0, "R3 single expiry", s, 0);
    end

    // R2 R12: divide keeps bits 2:0 only
    wr(2'd1, 32'h0000_00FD); rd(2'd1, d); check(d == 5, "R2 divide readback", d, 5);
    wr(2'd1, 32'd0);
    rd(2'd0, d); check(d == 32'h0002_0025, "R12 entry readback", d, 32'h0002_0025);

    // R10 R11: one-shot finished, then switched to periodic
    wr(2'd0, 32'h0000_005A); wr(2'd2, 32'd3);
    wait_irq(10, 1'b1, f, s, v); check(f == 4, "R3 one-shot", f, 4);
    rd(2'd3, d); check(d == 0, "R10 expired count", d, 0);
    wr(2'd0, 32'h0002_005A);
    wait_irq(10, 1'b1, f, s, v); check(f == 2, "R11 mode switch boundary", f, 2);

    // R11: unmask before count reached
    wr(2'd0, 32'h0001_0050); wr(2'd2, 32'd10);
    repeat (3) @(negedge clk);
    wr(2'd0, 32'h0000_0050);
    wait_irq(20, 1'b1, f, s, v); check(f == 7, "R11 early unmask fires", f, 7);

    // R4 R11: unmask after count passed
    wr(2'd0, 32'h0001_0051); wr(2'd2, 32'd4);
    repeat (9) @(negedge clk);
    wr(2'd0, 32'h0000_0051);
    wait_irq(40, 1'b0, f, s, v); check(f == 0, "R4 late unmask silent", f, 0);

    // R1: masked from the start, and masked mid-run
    wr(2'd0, 32'h0001_0052); wr(2'd2, 32'd3);
    wait_irq(30, 1'b0, f, s, v); check(f == 0, "R1 masked one-shot", f, 0);
    wr(2'd0, 32'h0002_0053); wr(2'd2, 32'd2);
    wait_irq(10, 1'b1, f, s, v); check(f == 3, "R5 before mask", f, 3);
    wr(2'd0, 32'h0003_0053);
    wait_irq(30, 1'b0, f, s, v); check(f == 0, "R1 masked periodic", f, 0);

    // R6 / R4: zero counts
    wr(2'd0, 32'h0002_0054); wr(2'd2, 32'd0);
    wait_irq(50, 1'b0, f, s, v); check(f == 0, "R6 periodic zero", f, 0);
    rd(2'd3, d); check(d == 0, "R10 zero count read", d, 0);
    wr(2'd0, 32'h0000_0055); wr(2'd2, 32'd0);
    wait_irq(50, 1'b0, f, s, v); check(f == 0, "R4 one-shot zero", f, 0);

    // R8: reload restarts
    wr(2'd0, 32'h0002_0056); wr(2'd2, 32'd5);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'd5);
    wait_irq(20, 1'b1, f, s, v); check(f == 6, "R8 reload restart", f, 6);
    rd(2'd2, d); check(d == 5, "R12 init readback", d, 5);

    // R10: live counts
    wr(2'd0, 32'h0002_0057); wr(2'd2, 32'd4);
    repeat (6) @(negedge clk);
    rd(2'd3, d); check(d == 3, "R10 periodic count", d, 3);
    wr(2'd0, 32'h0000_0058); wr(2'd2, 32'd100);
    rd(2'd3, d); check(d == 100, "R10 one-shot at load", d, 100);
    repeat (3) @(negedge clk);
    rd(2'd3, d); check(d == 96, "R10 one-shot running", d, 96);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule